// File: doc/BRIEF.md
# PLL output frequency decoder

This block works out the present output frequency, in kHz, of the core, shader and memory clock domains. It reads snapshots of the PLL setup words: a master source-select word, the control word of a single-stage PLL, and two control/coefficient pairs belonging to two-stage PLLs. One pair is shared by the core and shader domains and the other serves the memory domain only.

A caller puts the domain code on `dom_sel`, holds the register snapshots steady and pulses `start`. The block captures every field it needs in that cycle. It then multiplies by the feedback count and divides by the reference divider with a restoring divider that yields one quotient bit per cycle. When the second stage is active it makes a second multiply-and-divide pass. Last it applies the post-divider shift and presents the result with a one-cycle `done` strobe. Settings that are disabled or unusable give zero and skip the divider.

Top module: `pll_freq_decoder`

## Requirements
- R1: The single-stage word gives post-divider P in bits 18:16, feedback count N in bits 15:8 and reference divider M in bits 7:0. An enabled single-stage PLL reports (27000*N/M) >> P.
- R2: A two-stage coefficient word gives N2 in bits 31:24, M2 in bits 23:16, N1 in bits 15:8 and M1 in bits 7:0. P is taken from bits 18:16 of the matching control word. When control bit 30 is 1 and bit 8 is 0, the result is ((27000*N1/M1)*N2/M2) >> P.
- R3: In a two-stage PLL whose control bit 30 is 0, or whose bit 8 is 1, the second stage is bypassed and the result is (27000*N1/M1) >> P.
- R4: When bit 31 of the selected control word is 0, the PLL is disabled and the result is 0.
- R5: The result is 0 when the single-stage M is 0, when the two-stage M1 is 0, or when M2 is 0 while the second stage is active.
- R6: dom_sel 0 selects core, which takes its source from master bits 1:0. dom_sel 1 selects shader, which takes its source from master bits 5:4. Source 3 decodes the shared two-stage pair, source 2 decodes the single-stage word, and sources 0 and 1 give 0.
- R7: dom_sel 2 always decodes the memory two-stage pair, whatever the master word holds. dom_sel 3 gives 0.
- R8: Each division truncates toward zero. Intermediate products are carried in at least 40 bits, so the largest settings give exact results.
- R9: A start pulse that arrives while busy is high is ignored. All inputs are sampled only in the cycle in which start is accepted.
- R10: After an accepted start, busy is high from the next cycle until done. done is high for exactly one cycle, with busy low. freq_khz changes only in that cycle and then holds.
- R11: Reset clears busy, done and freq_khz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode |
| dom_sel | input | 2 | 0 core, 1 shader, 2 memory, 3 none |
| mast_sel | input | 32 | Master source-select snapshot |
| spll_ctrl | input | 32 | Single-stage PLL control word |
| npll_ctrl | input | 32 | Shared two-stage PLL control word |
| npll_coef | input | 32 | Shared two-stage PLL coefficients |
| mpll_ctrl | input | 32 | Memory two-stage PLL control word |
| mpll_coef | input | 32 | Memory two-stage PLL coefficients |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle result strobe |
| freq_khz | output | 32 | Decoded frequency in kHz |

## Verification
The checker watches the handshake on every cycle. An accepted start raises busy. done lasts one cycle and only appears as busy drops. freq_khz never moves outside a done cycle. The arithmetic cannot be shown by those properties: the one-stage and two-stage formulas, the bypass flags, the zero-forcing cases, the source-select decoding and the truncation all rest on the bench's scenarios. The same holds for ignoring a start while busy and for capturing the inputs at start, which the bench shows by changing the inputs partway through a decode.

// File: rtl/pll_freq_decoder.sv
module pll_freq_decoder #(
  parameter int DW      = 40,
  parameter int FW      = 32,
  parameter int REF_KHZ = 27000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    dom_sel,
  input  logic [31:0]   mast_sel,
  input  logic [31:0]   spll_ctrl,
  input  logic [31:0]   npll_ctrl,
  input  logic [31:0]   npll_coef,
  input  logic [31:0]   mpll_ctrl,
  input  logic [31:0]   mpll_coef,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] freq_khz
);
  localparam int CW = $clog2(DW);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} st_t;
  st_t st;

  logic [DW-1:0] q;
  logic [7:0]    r, dv, n2, m2;
  logic [CW-1:0] cnt;
  logic [2:0]    p;
  logic          st2;

  logic [1:0]  src;
  logic [31:0] c_ctl, c_coef;
  logic        c_ok, c_two, c_st2, c_zero;

  assign src = (dom_sel == 2'd0) ? mast_sel[1:0] : mast_sel[5:4];

  always_comb begin
    c_ok   = 1'b1;
    c_two  = 1'b1;
    c_ctl  = npll_ctrl;
    c_coef = npll_coef;
    if (dom_sel == 2'd2) begin
      c_ctl  = mpll_ctrl;
      c_coef = mpll_coef;
    end else if (dom_sel == 2'd3) begin
      c_ok = 1'b0;
    end else if (src == 2'd2) begin
      c_two  = 1'b0;
      c_ctl  = spll_ctrl;
      c_coef = {16'h0, spll_ctrl[15:0]};
    end else if (src != 2'd3) begin
      c_ok = 1'b0;
    end
  end

  assign c_st2  = c_two & c_ctl[30] & ~c_ctl[8];
  assign c_zero = ~c_ok | ~c_ctl[31] | (c_coef[7:0] == 8'd0) |
                  (c_st2 & (c_coef[23:16] == 8'd0));

  logic unused_bits;
  assign unused_bits = ^{mast_sel[31:6], mast_sel[3:2], c_ctl[29:19],
                         c_ctl[15:9], c_ctl[7:0]};

  logic [8:0]    rs;
  logic          ge;
  logic [7:0]    rn;
  logic [DW-1:0] qn, prod;

  assign rs   = {r, q[DW-1]};
  assign ge   = rs >= {1'b0, dv};
  assign rn   = ge ? 8'(rs - {1'b0, dv}) : rs[7:0];
  assign qn   = {q[DW-2:0], ge};
  assign prod = qn * {{(DW-8){1'b0}}, n2};

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      q        <= '0;
      r        <= '0;
      dv       <= '0;
      n2       <= '0;
      m2       <= '0;
      cnt      <= '0;
      p        <= '0;
      st2      <= 1'b0;
      freq_khz <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          p   <= c_ctl[18:16];
          n2  <= c_coef[31:24];
          m2  <= c_coef[23:16];
          st2 <= c_st2;
          dv  <= c_coef[7:0];
          r   <= '0;
          cnt <= '0;
          if (c_zero) begin
            q  <= '0;
            st <= S_FIN;
          end else begin
            q  <= DW'(REF_KHZ) * {{(DW-8){1'b0}}, c_coef[15:8]};
            st <= S_DIV;
          end
        end
        S_DIV: begin
          q   <= qn;
          r   <= rn;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DW-1)) begin
            if (st2) begin
              q   <= prod;
              r   <= '0;
              dv  <= m2;
              cnt <= '0;
              st2 <= 1'b0;
            end else begin
              st <= S_FIN;
            end
          end
        end
        default: begin
          freq_khz <= FW'(q >> p);
          done     <= 1'b1;
          st       <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module pll_freq_decoder_chk #(
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [FW-1:0] freq_khz
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(freq_khz));
  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
endmodule

bind pll_freq_decoder pll_freq_decoder_chk #(.FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .freq_khz(freq_khz)
);

// File: tb/pll_freq_decoder_test.sv
module pll_freq_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] dom_sel = '0;
  logic [31:0] mast_sel = '0, spll_ctrl = '0, npll_ctrl = '0, npll_coef = '0, mpll_ctrl = '0, mpll_coef = '0;
  logic busy, done;
  logic [31:0] freq_khz;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pll_freq_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dom_sel(dom_sel), .mast_sel(mast_sel),
    .spll_ctrl(spll_ctrl), .npll_ctrl(npll_ctrl), .npll_coef(npll_coef),
    .mpll_ctrl(mpll_ctrl), .mpll_coef(mpll_coef),
    .busy(busy), .done(done), .freq_khz(freq_khz)
  );

  typedef struct packed {
    logic [1:0]  dom;
    logic [31:0] mast, sctl, nctl, ncoef, mctl, mcoef;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0000_0002, 32'h8002_3C05, 32'h0, 32'h0, 32'h0, 32'h0},
    '{2'd0, 32'h0000_0003, 32'h0, 32'hC001_0000, 32'h0A03_2801, 32'h0, 32'h0},
    '{2'd0, 32'h0000_0003, 32'h0, 32'hC000_0100, 32'h0A03_2801, 32'h0, 32'h0},
    '{2'd0, 32'h0000_0003, 32'h0, 32'h8000_0000, 32'h0A03_2801, 32'h0, 32'h0},
    '{2'd0, 32'h0000_0003, 32'h0, 32'h4001_0000, 32'h0A03_2801, 32'h0, 32'h0},
    '{2'd0, 32'h0000_0003, 32'h0, 32'h8000_0000, 32'h0A03_2800, 32'h0, 32'h0},
    '{2'd0, 32'h0000_0003, 32'h0, 32'hC000_0000, 32'h0A00_2801, 32'h0, 32'h0},
    '{2'd1, 32'h0000_0023, 32'h8001_4B07, 32'hC000_0000, 32'h0A03_2801, 32'h0, 32'h0},
    '{2'd1, 32'h0000_0013, 32'h8001_4B07, 32'hC000_0000, 32'h0A03_2801, 32'h0, 32'h0},
    '{2'd0, 32'h0000_0030, 32'h8001_4B07, 32'hC000_0000, 32'h0A03_2801, 32'h0, 32'h0},
    '{2'd2, 32'h0000_0000, 32'h0, 32'h0, 32'h0, 32'hC002_0000, 32'h0705_6407},
    '{2'd3, 32'h0000_0033, 32'h8001_4B07, 32'hC000_0000, 32'h0A03_2801, 32'hC000_0000, 32'h0705_6407},
    '{2'd0, 32'h0000_0002, 32'h8000_1000, 32'h0, 32'h0, 32'h0, 32'h0},
    '{2'd2, 32'h0000_0000, 32'h0, 32'h0, 32'h0, 32'hC000_0000, 32'hFF01_FF01},
    '{2'd2, 32'h0000_0002, 32'h8000_0101, 32'h0, 32'h0, 32'h8007_0000, 32'hFFFF_FFFF}
  };

  localparam string TAGS [NV] = '{"R1", "R2", "R3", "R3", "R4", "R5", "R5", "R6", "R6",
                                  "R6", "R7", "R7", "R5", "R8", "R8"};

  function automatic longint model(vec_t v);
    longint ctl, coef, f, n1, m1, nn2, mm2;
    logic [1:0] s;
    bit two;
    s = (v.dom == 2'd0) ? v.mast[1:0] : v.mast[5:4];
    if (v.dom == 2'd3) return 0;
    if (v.dom == 2'd2) begin ctl = longint'(v.mctl); coef = longint'(v.mcoef); two = 1; end
    else if (s == 2'd3) begin ctl = longint'(v.nctl); coef = longint'(v.ncoef); two = 1; end
    else if (s == 2'd2) begin ctl = longint'(v.sctl); coef = longint'(v.sctl & 32'hFFFF); two = 0; end
    else return 0;
    if (((ctl >> 31) & 1) == 0) return 0;
    n1 = (coef >> 8) & 255; m1 = coef & 255;
    nn2 = (coef >> 24) & 255; mm2 = (coef >> 16) & 255;
    if (m1 == 0) return 0;
    f = 27000 * n1 / m1;
    if (two && ((ctl >> 30) & 1) == 1 && ((ctl >> 8) & 1) == 0) begin
      if (mm2 == 0) return 0;
      f = f * nn2 / mm2;
    end
    return f >> ((ctl >> 16) & 7);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    dom_sel = v.dom; mast_sel = v.mast; spll_ctrl = v.sctl; npll_ctrl = v.nctl;
    npll_coef = v.ncoef; mpll_ctrl = v.mctl; mpll_coef = v.mcoef;
  endtask

  task automatic wait_done(input string tag, output bit ok);
    int n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    ok = done;
    check(tag, longint'(done), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy", longint'(busy), 0);
    check("R11 done", longint'(done), 0);
    check("R11 freq", longint'(freq_khz), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R10 busy after accepted start
      check("R10 busy", longint'(busy), 1);
      wait_done(TAGS[i], ok);
      check(TAGS[i], longint'(freq_khz), model(VECS[i]));
      check("R10 idle at done", longint'(busy), 0);
      held = freq_khz;
      @(negedge clk);
      check("R10 one-cycle done", longint'(done), 0);
      check("R10 held", longint'(freq_khz), longint'(held));
      repeat (3) @(negedge clk);
      check("R10 still held", longint'(freq_khz), longint'(held));
    end

    // R9 start while busy ignored, inputs captured at start
    apply(VECS[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    apply(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    apply(VECS[11]);
    wait_done("R9 done", ok);
    check("R9 captured", longint'(freq_khz), model(VECS[1]));
    begin
      int extra = 0;
      for (int k = 0; k < 120; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R9 no second done", extra, 0);
      check("R9 busy low", longint'(busy), 0);
    end

    // R11 reset mid-run clears state
    apply(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 busy mid", longint'(busy), 0);
    check("R11 freq mid", longint'(freq_khz), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule